// File: doc/BRIEF.md
# Tiny 12-bit Load/Store Core

A small single-cycle processor. Each clock it fetches one 12-bit instruction, decodes it and retires it. Both instructions and data are 12-bit words. Operands come from four general registers. One adder does all the work: it adds or subtracts operands, compares operands for branches, and forms load and store addresses. Subtraction complements the second operand and forces the carry-in to one. All arithmetic is unsigned, and any carry out of the word is dropped.

Instruction memory and data memory are separate, and each is addressed by word. The program is written into instruction memory through a dedicated write port while reset is held. The program counter and all four registers are visible on debug outputs, so a program's progress can be followed cycle by cycle.

Top module: `tiny_ls_core`

## Requirements
- R1: While `rst_ni` is low (asynchronous, active low), the program counter and all four registers read zero. Register n is shown on `regs_o[12n+11:12n]`.
- R2: A word written through `imem_we_i`/`imem_waddr_i`/`imem_wdata_i` while reset is held is the instruction fetched when the PC's low address bits equal that address.
- R3: Opcodes 000 (add) and 001 (sub) use field [8:7] as operand A and [6:5] as operand B. They write A+B or A-B to the register named by bits [4:3]. Bits [2:0] are ignored.
- R4: Opcodes 010 (addi) and 011 (subi) write A+imm or A-imm to the register named by bits [6:5]. Here imm is bits [4:0] zero-extended to 12 bits.
- R5: Every result is taken modulo 4096. A sum that overflows wraps, and a negative difference becomes its 12-bit unsigned value.
- R6: Any instruction other than a taken branch sets the next PC to PC+1.
- R7: Opcode 100 is taken when A-B is zero, and opcode 101 is taken when A-B is non-zero. A taken branch sets the next PC to PC+imm, with no extra +1; imm 0 holds the PC.
- R8: Opcode 110 writes register B to data word A+imm. Branches and stores leave every register unchanged.
- R9: Opcode 111 loads data word A+imm into the register named by bits [6:5]. The data memory is indexed by the low log2(DMEM_DEPTH) bits of A+imm.
- R10: The all-zero word executes as r0 = r0 + r0, and register 0 is an ordinary writable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Instruction memory write strobe |
| imem_waddr_i | input | log2(IMEM_DEPTH) | Instruction memory write address |
| imem_wdata_i | input | 12 | Instruction word to write |
| pc_o | output | 12 | Current program counter |
| regs_o | output | 48 | Registers 3..0 packed, register n at [12n+11:12n] |

## Verification
The bench builds the core with IMEM_DEPTH=32 and DMEM_DEPTH=64. The 32-word instruction memory is filled completely by the first program, and the following reset then loads a second program over part of it. The 64-word data memory keeps the computed store and load addresses (39 and 31) inside one array without aliasing, so a load returns exactly the value an earlier store placed. A behavioural reference model runs alongside the core and is compared with the PC and all registers on every clock. Final register values that exercise wrap-around on both sum and difference are also checked directly.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int unsigned XLEN = 12;
  localparam int unsigned NREG = 4;
  localparam int unsigned RIDX = $clog2(NREG);
  localparam int unsigned IMMW = 5;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RIDX-1:0] ridx_t;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_ADDI = 3'b010,
    OP_SUBI = 3'b011,
    OP_BEQ  = 3'b100,
    OP_BNE  = 3'b101,
    OP_SW   = 3'b110,
    OP_LW   = 3'b111
  } op_e;

  typedef struct packed {
    op_e   op;
    ridx_t ra;
    ridx_t rb;
    ridx_t rd;
    word_t imm;
    logic  use_imm;
    logic  sub;
    logic  reg_we;
    logic  mem_we;
    logic  wb_mem;
    logic  is_br;
    logic  br_ne;
  } ctrl_t;
endpackage

// File: rtl/tlc_ram.sv
module tlc_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 12,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // combinational read
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tlc_decode.sv
module tlc_decode
  import tlc_pkg::*;
(
  input  word_t instr_i,
  output ctrl_t ctrl_o
);
  always_comb begin
    ctrl_o     = '0;
    ctrl_o.op  = op_e'(instr_i[11:9]);
    ctrl_o.ra  = instr_i[8:7];
    ctrl_o.rb  = instr_i[6:5];
    // register format when opcode top bits are 00
    ctrl_o.rd  = (instr_i[11:10] == 2'b00) ? instr_i[4:3] : instr_i[6:5];
    ctrl_o.imm = {{(XLEN-IMMW){1'b0}}, instr_i[IMMW-1:0]};
    case (ctrl_o.op)
      OP_ADD:  ctrl_o.reg_we = 1'b1;
      OP_SUB:  begin ctrl_o.sub = 1'b1; ctrl_o.reg_we = 1'b1; end
      OP_ADDI: begin ctrl_o.use_imm = 1'b1; ctrl_o.reg_we = 1'b1; end
      OP_SUBI: begin ctrl_o.use_imm = 1'b1; ctrl_o.sub = 1'b1; ctrl_o.reg_we = 1'b1; end
      OP_BEQ:  begin ctrl_o.sub = 1'b1; ctrl_o.is_br = 1'b1; end
      OP_BNE:  begin ctrl_o.sub = 1'b1; ctrl_o.is_br = 1'b1; ctrl_o.br_ne = 1'b1; end
      OP_SW:   begin ctrl_o.use_imm = 1'b1; ctrl_o.mem_we = 1'b1; end
      OP_LW:   begin ctrl_o.use_imm = 1'b1; ctrl_o.reg_we = 1'b1; ctrl_o.wb_mem = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tlc_regfile.sv
module tlc_regfile #(
  parameter int unsigned NREG = 4,
  parameter int unsigned W    = 12,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [W-1:0]    rdata_a_o,
  output logic [W-1:0]    rdata_b_o,
  output logic [NREG*W-1:0] regs_o
);
  logic [W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))       q[i] <= wdata_i;
    end
    assign regs_o[i*W +: W] = q[i];
  end

  assign rdata_a_o = q[raddr_a_i];
  assign rdata_b_o = q[raddr_b_i];
endmodule

// File: rtl/tlc_addsub.sv
module tlc_addsub #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         zero_o
);
  logic [W-1:0] b_x;

  // subtract as a + ~b + 1; carry out dropped
  assign b_x    = sub_i ? ~b_i : b_i;
  assign sum_o  = a_i + b_x + {{(W-1){1'b0}}, sub_i};
  assign zero_o = (sum_o == '0);
endmodule

// File: rtl/tiny_ls_core.sv
module tiny_ls_core
  import tlc_pkg::*;
#(
  parameter int unsigned IMEM_DEPTH = 64,
  parameter int unsigned DMEM_DEPTH = 64,
  localparam int unsigned IAW = $clog2(IMEM_DEPTH),
  localparam int unsigned DAW = $clog2(DMEM_DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 imem_we_i,
  input  logic [IAW-1:0]       imem_waddr_i,
  input  logic [XLEN-1:0]      imem_wdata_i,
  output logic [XLEN-1:0]      pc_o,
  output logic [NREG*XLEN-1:0] regs_o
);
  word_t pc_q, pc_d, pc_step;
  word_t instr, ra_val, rb_val, alu_b, alu_y, ld_data, wb_data;
  ctrl_t ctrl;
  logic  alu_zero, br_take;

  tlc_ram #(.DEPTH(IMEM_DEPTH), .W(XLEN)) u_imem (
    .clk_i   (clk_i),
    .we_i    (imem_we_i),
    .waddr_i (imem_waddr_i),
    .wdata_i (imem_wdata_i),
    .raddr_i (pc_q[IAW-1:0]),
    .rdata_o (instr)
  );

  tlc_decode u_dec (
    .instr_i (instr),
    .ctrl_o  (ctrl)
  );

  tlc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl.reg_we),
    .waddr_i   (ctrl.rd),
    .wdata_i   (wb_data),
    .raddr_a_i (ctrl.ra),
    .raddr_b_i (ctrl.rb),
    .rdata_a_o (ra_val),
    .rdata_b_o (rb_val),
    .regs_o    (regs_o)
  );

  assign alu_b = ctrl.use_imm ? ctrl.imm : rb_val;

  tlc_addsub #(.W(XLEN)) u_alu (
    .a_i    (ra_val),
    .b_i    (alu_b),
    .sub_i  (ctrl.sub),
    .sum_o  (alu_y),
    .zero_o (alu_zero)
  );

  // single data address feeds both read and write
  tlc_ram #(.DEPTH(DMEM_DEPTH), .W(XLEN)) u_dmem (
    .clk_i   (clk_i),
    .we_i    (ctrl.mem_we & rst_ni),
    .waddr_i (alu_y[DAW-1:0]),
    .wdata_i (rb_val),
    .raddr_i (alu_y[DAW-1:0]),
    .rdata_o (ld_data)
  );

  assign wb_data = ctrl.wb_mem ? ld_data : alu_y;

  // taken branch replaces the +1 step with the offset
  assign br_take = ctrl.is_br & (alu_zero ^ ctrl.br_ne);
  assign pc_step = br_take ? ctrl.imm : word_t'(1);
  assign pc_d    = pc_q + pc_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk
  import tlc_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [XLEN-1:0]      pc_o,
  input logic [NREG*XLEN-1:0] regs_o,
  input logic [XLEN-1:0]      instr_i
);
  function automatic word_t rv(input logic [NREG*XLEN-1:0] r, input ridx_t i);
    return r[i*XLEN +: XLEN];
  endfunction

  word_t a_v, b_v, imm_v, add_exp, addi_exp, pc_plus1, pc_tgt;
  logic [2:0] op;
  assign op       = instr_i[11:9];
  assign a_v      = rv(regs_o, instr_i[8:7]);
  assign b_v      = rv(regs_o, instr_i[6:5]);
  assign imm_v    = {{(XLEN-IMMW){1'b0}}, instr_i[IMMW-1:0]};
  assign add_exp  = a_v + b_v;
  assign addi_exp = a_v + imm_v;
  assign pc_plus1 = pc_o + 12'd1;
  assign pc_tgt   = pc_o + imm_v;

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (pc_o == '0 && regs_o == '0));

  // R6
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op[2:1] != 2'b10) |=> pc_o == $past(pc_plus1));

  // R7
  br_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op == 3'b100 && a_v == b_v) || (op == 3'b101 && a_v != b_v)) |=> pc_o == $past(pc_tgt));

  // R8
  no_reg_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op[2:1] == 2'b10 || op == 3'b110) |=> $stable(regs_o));

  // R3
  add_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 3'b000) |=> rv(regs_o, $past(instr_i[4:3])) == $past(add_exp));

  // R4
  addi_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 3'b010) |=> rv(regs_o, $past(instr_i[6:5])) == $past(addi_exp));
endmodule

bind tiny_ls_core tlc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pc_o    (pc_o),
  .regs_o  (regs_o),
  .instr_i (instr)
);

// File: tb/tb_tiny_ls_core.sv
`timescale 1ns/1ps
module tb_tiny_ls_core;
  localparam int IMEM_DEPTH = 32;
  localparam int DMEM_DEPTH = 64;
  localparam int IAW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic imem_we_i = 1'b0;
  logic [IAW-1:0] imem_waddr_i = '0;
  logic [11:0] imem_wdata_i = '0;
  logic [11:0] pc_o;
  logic [47:0] regs_o;

  always #2 clk_i = ~clk_i;

  tiny_ls_core #(.IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .imem_we_i(imem_we_i),
    .imem_waddr_i(imem_waddr_i), .imem_wdata_i(imem_wdata_i),
    .pc_o(pc_o), .regs_o(regs_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] m_imem [IMEM_DEPTH];
  logic [11:0] m_dmem [DMEM_DEPTH];
  logic [11:0] m_regs [4];
  logic [11:0] m_pc;

  function automatic logic [11:0] enc_r(int op, int r1, int r2, int r3, int junk);
    return {op[2:0], r1[1:0], r2[1:0], r3[1:0], junk[2:0]};
  endfunction

  function automatic logic [11:0] enc_i(int op, int r1, int r2, int imm);
    return {op[2:0], r1[1:0], r2[1:0], imm[4:0]};
  endfunction

  function automatic logic [11:0] dreg(int i);
    return regs_o[i*12 +: 12];
  endfunction

  task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0;
    for (int i = 0; i < 4; i++) m_regs[i] = '0;
  endtask

  task automatic model_step(output string pc_tag, output string reg_tag);
    logic [11:0] ins, a, b, imm, addr;
    bit taken;
    ins  = m_imem[m_pc % IMEM_DEPTH];
    a    = m_regs[ins[8:7]];
    b    = m_regs[ins[6:5]];
    imm  = {7'd0, ins[4:0]};
    addr = a + imm;
    taken = 1'b0;
    pc_tag = "R6";
    case (ins[11:9])
      3'd0: begin m_regs[ins[4:3]] = a + b; reg_tag = (ins == 12'h000) ? "R10" : "R3"; end
      3'd1: begin m_regs[ins[4:3]] = a - b; reg_tag = "R5"; end
      3'd2: begin m_regs[ins[6:5]] = a + imm; reg_tag = "R4"; end
      3'd3: begin m_regs[ins[6:5]] = a - imm; reg_tag = "R4"; end
      3'd4, 3'd5: begin
        taken = (a == b) ^ ins[9];
        reg_tag = "R8";
        if (taken) pc_tag = "R7";
      end
      3'd6: begin m_dmem[addr % DMEM_DEPTH] = b; reg_tag = "R8"; end
      default: begin m_regs[ins[6:5]] = m_dmem[addr % DMEM_DEPTH]; reg_tag = "R9"; end
    endcase
    if (taken) m_pc = m_pc + imm;
    else       m_pc = m_pc + 12'd1;
  endtask

  // R2: preload through the write port while reset is held
  task automatic load_word(input int addr, input logic [11:0] w);
    @(negedge clk_i);
    imem_we_i = 1'b1;
    imem_waddr_i = addr[IAW-1:0];
    imem_wdata_i = w;
    m_imem[addr] = w;
    @(negedge clk_i);
    imem_we_i = 1'b0;
  endtask

  task automatic cmp_state(input string pc_tag, input string reg_tag);
    chk(pc_tag, "pc", {36'd0, pc_o}, {36'd0, m_pc});
    chk(reg_tag, "regs", regs_o, {m_regs[3], m_regs[2], m_regs[1], m_regs[0]});
  endtask

  task automatic run(input int n);
    string pt, rt;
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      model_step(pt, rt);
      @(negedge clk_i);
      cmp_state(pt, rt);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-path: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    model_reset();
    // program 1
    for (int i = 0; i < IMEM_DEPTH; i++) begin
      logic [11:0] w;
      case (i)
        0:  w = 12'h000;
        1:  w = enc_i(2, 0, 1, 31);
        2:  w = enc_i(2, 1, 2, 5);
        3:  w = enc_r(0, 1, 2, 3, 5);
        4:  w = enc_r(1, 1, 2, 0, 0);
        5:  w = enc_r(0, 0, 3, 0, 0);
        6:  w = enc_i(3, 1, 1, 31);
        7:  w = enc_i(6, 2, 3, 3);
        8:  w = enc_i(7, 2, 1, 3);
        9:  w = enc_i(4, 1, 3, 3);
        10: w = enc_i(2, 0, 0, 1);
        11: w = enc_i(2, 0, 0, 1);
        12: w = enc_i(5, 1, 3, 7);
        13: w = enc_i(3, 2, 2, 31);
        14: w = enc_i(3, 2, 2, 31);
        15: w = enc_r(0, 2, 3, 2, 7);
        default: w = enc_i(4, 0, 0, 0);
      endcase
      load_word(i, w);
    end
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "pc in reset", {36'd0, pc_o}, 48'd0);
    chk("R1", "regs in reset", regs_o, 48'd0);
    rst_ni = 1'b1;
    run(30);
    // R5 wrapped results, R7 self-loop with zero offset
    chk("R5", "r0 after sub then add wrap", {36'd0, dreg(0)}, 48'd62);
    chk("R5", "r2 after subi underflow and add", {36'd0, dreg(2)}, 48'd41);
    chk("R9", "r1 loaded from store", {36'd0, dreg(1)}, 48'd67);
    chk("R7", "pc held by zero offset", {36'd0, pc_o}, 48'd16);

    // second program after reset
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    chk("R1", "pc cleared mid-run", {36'd0, pc_o}, 48'd0);
    chk("R1", "regs cleared mid-run", regs_o, 48'd0);
    load_word(0, enc_i(2, 0, 3, 20));
    load_word(1, enc_i(6, 3, 3, 11));
    load_word(2, enc_i(7, 0, 0, 31));
    load_word(3, enc_i(5, 0, 1, 2));
    load_word(4, enc_i(2, 0, 1, 9));
    load_word(5, enc_i(3, 2, 2, 1));
    load_word(6, enc_i(2, 2, 2, 1));
    load_word(7, enc_i(4, 0, 0, 0));
    @(negedge clk_i);
    rst_ni = 1'b1;
    run(16);
    chk("R9", "r0 loaded from word 31", {36'd0, dreg(0)}, 48'd20);
    chk("R7", "skipped instruction left r1", {36'd0, dreg(1)}, 48'd0);
    chk("R5", "r2 wrapped back to zero", {36'd0, dreg(2)}, 48'd0);
    chk("R2", "pc at preloaded self-loop", {36'd0, pc_o}, 48'd7);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule